// File: doc/BRIEF.md
# Triggered Hit Delay and Serial Readout Buffer

This block sits at the front of a tracker readout chain. On every 40 MHz clock it takes in a 64-channel discriminated hit word and writes it into a circular delay memory. The read tap sits a configurable number of clocks behind the write position. When a Level-1 accept arrives, the tapped word is the hit pattern of the bunch crossing that caused the trigger. That word is masked per channel and stamped with the running bunch-crossing and event counters. It is then queued as one frame.

A downstream collector pulls frames with a two-wire handshake. The block raises `data_rdy_o` while a frame is waiting and the serializer is idle. The collector answers with `data_req_i`. A frame starts only on a clock edge where both are high. The block then drives one bit per clock on `ser_data_o`, framed by `ser_valid_o`. After that start the collector can neither pause the frame nor hold it back. Its only back-pressure is to withhold `data_req_i`, and frames wait in a four-entry queue while it does. An accept that finds the queue full is discarded and sets a sticky overflow flag. Configuration is written through a plain parallel port: address 0 holds the latency, and addresses 1 and 2 hold the low and high mask words.

Top module: `lrb_top`

## Requirements
- R1: Every clock edge stores `hit_i` into the delay memory. An accept at edge k with effective latency L captures the word that was present at edge k−L.
- R2: The latency is an 8-bit value written at config address 0 from `cfg_wdata_i[7:0]`. It is 1 after reset, and a stored value of 0 acts as 1.
- R3: Mask bits are written at config address 1 (channels 31..0) and address 2 (channels 63..32). A mask bit of 1 forces that channel to 0 in every captured frame, and the mask in force at the accept edge is the one applied.
- R4: A 12-bit bunch counter advances by one each clock and wraps from 4095 to 0. `bcr_i` loads it with 0 at that edge. A frame carries the counter value held just before its accept edge.
- R5: An 8-bit event counter advances on every accept, including dropped ones. `ecr_i` loads it with 0 and wins over a coinciding accept. A frame carries the counter value held just before its accept edge.
- R6: The queue holds 4 frames. An accept that arrives while 4 frames are waiting is dropped, and `ovf_o` then stays 1 until reset.
- R7: `data_rdy_o` is 1 exactly when at least one frame is queued and no frame is being sent. `data_req_i` has no effect while `data_rdy_o` is 0.
- R8: After a start edge, `ser_valid_o` is 1 for exactly 84 clocks and `ser_data_o` carries one bit per clock. The order is bunch ID (12 bits), event ID (8 bits), then hit channels 63 down to 0, each field MSB first. `ser_data_o` is 0 whenever `ser_valid_o` is 0.
- R9: Frames leave in the order their accepts were taken.
- R10: After reset, `data_rdy_o`, `ser_valid_o`, `ser_data_o` and `ovf_o` are 0, and both counters start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 64 | Discriminated hit word for this crossing |
| l1a_i | input | 1 | Level-1 accept |
| bcr_i | input | 1 | Bunch counter reset |
| ecr_i | input | 1 | Event counter reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 3 | Config address: 0 latency, 1 mask low, 2 mask high |
| cfg_wdata_i | input | 32 | Config write data |
| data_req_i | input | 1 | Collector request to start a frame |
| data_rdy_o | output | 1 | A frame is waiting and the line is idle |
| ser_valid_o | output | 1 | A frame bit is on the line |
| ser_data_o | output | 1 | Serial frame bit |
| ovf_o | output | 1 | Sticky drop flag |

## Verification
Two functions can land on the same edge.

The first case is an accept together with an event counter reset. The bench schedules this at a fixed offset in each latency segment. It judges the result from the event field of that frame, which must hold the pre-reset count, and from the next frame's tag, which must restart from zero.

The second case is an accept on the same edge that the serializer pops a frame. Six back-to-back accepts under a mostly-high request pattern push the queue into its full state while pops are still happening. The bench's arithmetic queue model then decides which accepts survive, when `ovf_o` rises, and whether each later frame carries the correct bits.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  typedef enum logic {SER_IDLE = 1'b0, SER_SHIFT = 1'b1} ser_state_e;

  localparam int unsigned CFG_AW      = 3;
  localparam logic [CFG_AW-1:0] CFG_LAT  = 3'd0;
  localparam logic [CFG_AW-1:0] CFG_MSK0 = 3'd1;
endpackage

// File: rtl/lrb_delay_line.sv
module lrb_delay_line
  import lrb_pkg::*;
#(
  parameter int unsigned CH   = 64,
  parameter int unsigned LATW = 8,
  parameter int unsigned CFGW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     hit_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFGW-1:0]   cfg_wdata_i,
  output logic [CH-1:0]     tap_o
);
  localparam int unsigned DEPTH = 2 ** LATW;
  localparam int unsigned NW    = CH / CFGW;

  logic [CH-1:0]   mem [DEPTH];
  logic [LATW-1:0] wp_q;
  logic [LATW-1:0] lat_q;
  logic [LATW-1:0] lat_eff;
  logic [LATW-1:0] rp;
  logic [CH-1:0]   mask_q;

  always_ff @(posedge clk) begin
    mem[wp_q] <= hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      lat_q <= LATW'(1);
    end else begin
      wp_q <= wp_q + 1'b1;
      if (cfg_we_i && cfg_addr_i == CFG_LAT) lat_q <= cfg_wdata_i[LATW-1:0];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[w*CFGW +: CFGW] <= '0;
      else if (cfg_we_i && cfg_addr_i == CFG_AW'(CFG_MSK0 + w))
        mask_q[w*CFGW +: CFGW] <= cfg_wdata_i;
    end
  end

  always_comb begin
    lat_eff = (lat_q == '0) ? LATW'(1) : lat_q;
    rp      = wp_q - lat_eff;
    tap_o   = mem[rp] & ~mask_q;
  end
endmodule

// File: rtl/lrb_tagger.sv
module lrb_tagger #(
  parameter int unsigned BCW = 12,
  parameter int unsigned EVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bcr_i,
  input  logic           ecr_i,
  input  logic           l1a_i,
  output logic [BCW-1:0] bcid_o,
  output logic [EVW-1:0] l1id_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcid_o <= '0;
      l1id_o <= '0;
    end else begin
      bcid_o <= bcr_i ? '0 : bcid_o + 1'b1;
      if (ecr_i)      l1id_o <= '0;
      else if (l1a_i) l1id_o <= l1id_o + 1'b1;
    end
  end

  p_bc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bcr_i |=> bcid_o == BCW'($past(bcid_o) + 1'b1));
  p_ecr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_i |=> l1id_o == '0);
endmodule

// File: rtl/lrb_evq.sv
module lrb_evq #(
  parameter int unsigned W     = 84,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         nempty_o,
  output logic         ovf_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          take;

  assign full     = (cnt_q == CW'(DEPTH));
  assign take     = push_i && !full;
  assign nempty_o = (cnt_q != '0);
  assign dout_o   = slot[rd_q];

  always_ff @(posedge clk) begin
    if (take) slot[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (take)  wr_q <= wr_q + 1'b1;
      if (pop_i) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(take) - CW'(pop_i);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> ovf_o);
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> nempty_o);
endmodule

// File: rtl/lrb_ser.sv
module lrb_ser
  import lrb_pkg::*;
#(
  parameter int unsigned W = 84
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         have_i,
  input  logic [W-1:0] frame_i,
  input  logic         req_i,
  output logic         pop_o,
  output logic         rdy_o,
  output logic         sdata_o,
  output logic         svalid_o
);
  localparam int unsigned CNTW = $clog2(W);

  ser_state_e      st_q;
  logic [W-1:0]    sh_q;
  logic [CNTW-1:0] cnt_q;

  assign rdy_o    = have_i && (st_q == SER_IDLE);
  assign pop_o    = rdy_o && req_i;
  assign svalid_o = (st_q == SER_SHIFT);
  assign sdata_o  = svalid_o && sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SER_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (st_q == SER_SHIFT) begin
      sh_q <= sh_q << 1;
      if (cnt_q == '0) st_q  <= SER_IDLE;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (pop_o) begin
      sh_q  <= frame_i;
      cnt_q <= CNTW'(W - 1);
      st_q  <= SER_SHIFT;
    end
  end

  p_start_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svalid_o) |-> $past(req_i && have_i));
endmodule

// File: rtl/lrb_top.sv
module lrb_top
  import lrb_pkg::*;
#(
  parameter int unsigned CH     = 64,
  parameter int unsigned LATW   = 8,
  parameter int unsigned CFGW   = 32,
  parameter int unsigned BCW    = 12,
  parameter int unsigned EVW    = 8,
  parameter int unsigned QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     hit_i,
  input  logic              l1a_i,
  input  logic              bcr_i,
  input  logic              ecr_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFGW-1:0]   cfg_wdata_i,
  input  logic              data_req_i,
  output logic              data_rdy_o,
  output logic              ser_valid_o,
  output logic              ser_data_o,
  output logic              ovf_o
);
  localparam int unsigned FW = BCW + EVW + CH;

  logic [CH-1:0]  tap;
  logic [BCW-1:0] bcid;
  logic [EVW-1:0] l1id;
  logic [FW-1:0]  head;
  logic           nempty;
  logic           pop;

  lrb_delay_line #(.CH(CH), .LATW(LATW), .CFGW(CFGW)) u_dl (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .tap_o(tap)
  );

  lrb_tagger #(.BCW(BCW), .EVW(EVW)) u_tag (
    .clk(clk), .rst_n(rst_n), .bcr_i(bcr_i), .ecr_i(ecr_i), .l1a_i(l1a_i),
    .bcid_o(bcid), .l1id_o(l1id)
  );

  lrb_evq #(.W(FW), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_i(l1a_i), .din_i({bcid, l1id, tap}),
    .pop_i(pop), .dout_o(head), .nempty_o(nempty), .ovf_o(ovf_o)
  );

  lrb_ser #(.W(FW)) u_ser (
    .clk(clk), .rst_n(rst_n), .have_i(nempty), .frame_i(head),
    .req_i(data_req_i), .pop_o(pop), .rdy_o(data_rdy_o),
    .sdata_o(ser_data_o), .svalid_o(ser_valid_o)
  );

  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid_o |-> !ser_data_o);
endmodule

// File: tb/tb_lrb_top.sv
module tb_lrb_top;
  localparam time PERIOD = 25ns;
  localparam int  NSEG   = 18;
  localparam int  SEGLEN = 300;
  localparam int  LAST   = 300 + NSEG * SEGLEN + 900;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] hit_i;
  logic        l1a_i, bcr_i, ecr_i, cfg_we_i, data_req_i;
  logic [2:0]  cfg_addr_i;
  logic [31:0] cfg_wdata_i;
  logic        data_rdy_o, ser_valid_o, ser_data_o, ovf_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [63:0] hist [512];
  logic [83:0] mq [4];
  int          mhead = 0, mtail = 0, mcount = 0, mcnt = 0;
  logic        mbusy = 1'b0, movf = 1'b0;
  logic [83:0] msh = '0;
  logic [11:0] mbc = '0;
  logic [7:0]  mev = '0;
  logic [7:0]  mlat = 8'd1;
  logic [63:0] mmask = '0;

  always #(PERIOD/2) clk = ~clk;

  lrb_top dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .l1a_i(l1a_i), .bcr_i(bcr_i),
    .ecr_i(ecr_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .data_req_i(data_req_i),
    .data_rdy_o(data_rdy_o), .ser_valid_o(ser_valid_o),
    .ser_data_o(ser_data_o), .ovf_o(ovf_o)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  function automatic logic [63:0] pattern(input int k);
    logic [31:0] a, b;
    a = 32'(k) * 32'h9E3779B1;
    b = (32'(k) ^ 32'h00005A5A) * 32'h85EBCA77;
    return {a, b};
  endfunction

  function automatic logic [7:0] lat_of(input int s);
    case (s % 8)
      0: return 8'd1;    1: return 8'd2;   2: return 8'd3;   3: return 8'd7;
      4: return 8'd100;  5: return 8'd255; 6: return 8'd0;   default: return 8'd4;
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hit_i = '0; l1a_i = 0; bcr_i = 0; ecr_i = 0;
    cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0; data_req_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk(data_rdy_o, 1'b0, "R10 data_rdy_o after reset");
    chk(ser_valid_o, 1'b0, "R10 ser_valid_o after reset");
    chk(ser_data_o, 1'b0, "R10 ser_data_o after reset");
    chk(ovf_o, 1'b0, "R10 ovf_o after reset");

    for (int k = 0; k < LAST; k++) begin
      logic [7:0]  leff;
      logic [63:0] samp;
      logic        push, pop;
      int          s, o;

      // compare outputs produced by edge k-1
      if (k > 0) begin
        chk(data_rdy_o, (mcount > 0) && !mbusy, "R7 data_rdy_o");
        chk(ser_valid_o, mbusy, "R7 R8 ser_valid_o");
        chk(ovf_o, movf, "R6 ovf_o");
        if (mbusy) begin
          if (mcnt >= 72)      chk(ser_data_o, msh[83], "R4 R10 bunch field bit");
          else if (mcnt >= 64) chk(ser_data_o, msh[83], "R5 R10 event field bit");
          else                 chk(ser_data_o, msh[83], "R1 R2 R3 R9 hit field bit");
        end else begin
          chk(ser_data_o, 1'b0, "R8 idle line");
        end
      end

      // choose stimulus for edge k
      hit_i = pattern(k);
      l1a_i = 0; bcr_i = 0; ecr_i = 0; cfg_we_i = 0; cfg_addr_i = '0; cfg_wdata_i = '0;
      data_req_i = (k % 7) != 3;
      if (k >= 300 && k < 300 + NSEG * SEGLEN) begin
        s = (k - 300) / SEGLEN;
        o = (k - 300) % SEGLEN;
        if (o == 0) begin
          cfg_we_i = 1; cfg_addr_i = 3'd0; cfg_wdata_i = {24'd0, lat_of(s)};
        end
        if (s == 3 && o == 1) begin cfg_we_i = 1; cfg_addr_i = 3'd1; cfg_wdata_i = 32'hF0F0F0F0; end
        if (s == 3 && o == 2) begin cfg_we_i = 1; cfg_addr_i = 3'd2; cfg_wdata_i = 32'hFFFF0000; end
        if (s == 5 && o == 1) begin cfg_we_i = 1; cfg_addr_i = 3'd1; cfg_wdata_i = 32'h0; end
        if (s == 5 && o == 2) begin cfg_we_i = 1; cfg_addr_i = 3'd2; cfg_wdata_i = 32'h0; end
        // R6: burst of six accepts overruns the queue
        if (o >= 10 && o <= 15) l1a_i = 1;
        if (o == 120 || o == 121 || o == 200 || o == 250) l1a_i = 1;
        // R5: counter reset coinciding with an accept, and alone
        if (o == 121 || o == 60) ecr_i = 1;
        // R4: bunch reset, only early so the counter later wraps
        if (s < 4 && (o == 150 || o == 200)) bcr_i = 1;
        // R4: accepts around the natural wrap
        if (o > 20 && (mbc == 12'hFFF || mbc == 12'h000)) l1a_i = 1;
      end

      // model edge k
      leff = (mlat == 8'd0) ? 8'd1 : mlat;
      samp = hist[(k - int'(leff)) % 512] & ~mmask;
      hist[k % 512] = hit_i;
      pop  = (mcount > 0) && !mbusy && data_req_i;
      push = l1a_i && (mcount < 4);
      if (l1a_i && mcount == 4) movf = 1'b1;
      if (mbusy) begin
        msh = msh << 1;
        if (mcnt == 0) mbusy = 1'b0;
        else mcnt--;
      end else if (pop) begin
        msh = mq[mhead]; mcnt = 83; mbusy = 1'b1; mhead = (mhead + 1) % 4;
      end
      if (push) begin
        mq[mtail] = {mbc, mev, samp}; mtail = (mtail + 1) % 4;
      end
      mcount = mcount + (push ? 1 : 0) - (pop ? 1 : 0);
      mbc = bcr_i ? 12'd0 : mbc + 12'd1;
      if (ecr_i) mev = 8'd0;
      else if (l1a_i) mev = mev + 8'd1;
      if (cfg_we_i) begin
        if (cfg_addr_i == 3'd0) mlat = cfg_wdata_i[7:0];
        if (cfg_addr_i == 3'd1) mmask[31:0] = cfg_wdata_i;
        if (cfg_addr_i == 3'd2) mmask[63:32] = cfg_wdata_i;
      end

      @(negedge clk);
    end

    // R9: everything drained at the end
    chk(data_rdy_o, 1'b0, "R9 queue drained");
    chk(ovf_o, 1'b1, "R6 overflow sticky at end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule